// File: doc/BRIEF.md
# Register-Bus Core Address Selector

This block sits between one host register bus and a set of peripheral cores. The host presents an address, 32-bit write data, a chip-select and a write-enable. The selector works out which core owns that address and raises that core's chip-select. It also passes on the register address local to that core, and sends the selected core's read data and error flag back to the host. Each core owns a contiguous region of one or more 256-register blocks. Regions are laid out back to back from address 0 in core index order. For a core with several blocks, the block index within its region becomes the upper part of its local address, so sub-slots inside the core each consume a block.

Cores come in two kinds. Register-based cores present read data in the same cycle as their chip-select. Block-memory cores present it one cycle later. When at least one core in the build is of the block-memory kind, the selector adds one register stage to the read data and error of every register-based core. It also registers the read-mux select, so every core answers the host one cycle after the request. When no core uses block memory, the stage is not built and the return path is purely combinational. A core that has no error output contributes 0 to the error path. An address outside every region selects no core, returns zero data and raises the host error flag.

Top module: `csel_top`

## Requirements
- R1: With the default block counts (core0=1, core1=1, core2=16, core3=4 blocks), the regions start at block 0, 1, 2 and 18. A request whose address bits [ADDR_W-1:8] fall in a region raises exactly that core's bit of core_cs in the same cycle.
- R2: core_addr is 12 bits wide with the defaults. It equals {block index within the region (low 4 bits), host_addr[7:0]}. For example, host address 0x001105 gives core2 local address 0xF05.
- R3: A bit of core_we is 1 only when host_cs and host_we are both 1 and that core is selected. With host_we 0 every core_we bit is 0.
- R4: At most one core_cs bit is 1 in any cycle. With host_cs 0 all are 0.
- R5: When some core uses block memory (default: core3 only), the read data of a request made in cycle n appears on host_rdata in cycle n+1, for every core.
- R6: Requests issued on consecutive cycles each return their own core's data in order, one cycle later.
- R7: host_err carries the selected core's error with the same latency as its data. Cores without an error output (default: core1 and core3) return 0 whatever their core_err_in bit holds.
- R8: A request to an address outside all regions raises no core_cs. One cycle later it returns host_rdata 0 and host_err 1.
- R9: After reset, and one cycle after a cycle with host_cs 0, host_rdata is 0 and host_err is 0.
- R10: When no core uses block memory, host_rdata and host_err follow the request in the same cycle with no register stage. This also holds for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host request strobe |
| host_we | input | 1 | Host write enable |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data returned to the host |
| host_err | output | 1 | Error returned to the host |
| core_cs | output | N_CORES | Per-core chip-select |
| core_we | output | N_CORES | Per-core write enable |
| core_addr | output | LOCAL_W | Address local to the selected core |
| core_wdata | output | 32 | Write data to the cores |
| core_rdata | input | 32*N_CORES | Read data of all cores, core 0 in the low bits |
| core_err_in | input | N_CORES | Error flag of each core |

## Verification
Decode results (core_cs, core_we, core_addr) are combinational. The bench checks them 1 ns after it drives the request, in the same low clock phase. In the default build, read data and error are due one clock edge after the request. The bench drives each request at a falling edge and samples the response at the next falling edge, while the following request is already on the bus. This shows that each answer belongs to the earlier address. A second instance built without block memory is checked for read data and error in the same phase as its request.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int MAXC = 16;
  typedef logic [MAXC*8-1:0] cnt_vec_t;

  // first block of core idx: sum of counts of lower-index cores
  function automatic int blk_base(input cnt_vec_t c, input int idx);
    int s;
    s = 0;
    for (int k = 0; k < MAXC; k++)
      if (k < idx) s += int'(c[k*8 +: 8]);
    return s;
  endfunction

  function automatic int blk_max(input cnt_vec_t c, input int n);
    int m;
    m = 1;
    for (int k = 0; k < MAXC; k++)
      if (k < n && int'(c[k*8 +: 8]) > m) m = int'(c[k*8 +: 8]);
    return m;
  endfunction

  function automatic int local_width(input cnt_vec_t c, input int n);
    return 8 + $clog2(blk_max(c, n));
  endfunction
endpackage

// File: rtl/csel_decode.sv
module csel_decode #(
  parameter int ADDR_W = 24,
  parameter int N_CORES = 4,
  parameter logic [N_CORES*8-1:0] CORE_BLOCKS = {8'd4, 8'd16, 8'd1, 8'd1},
  parameter logic [N_CORES-1:0] CORE_ERR = 4'b0101,
  parameter int LOCAL_W = 12
) (
  input  logic                 host_cs,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [N_CORES-1:0]   core_err_in,
  output logic [N_CORES-1:0]   hit,
  output logic                 unmapped,
  output logic [LOCAL_W-1:0]   lcl_addr,
  output logic [N_CORES-1:0]   err_masked
);
  localparam int BLK_W = ADDR_W - 8;
  localparam csel_pkg::cnt_vec_t CNTS = csel_pkg::cnt_vec_t'(CORE_BLOCKS);

  logic [BLK_W-1:0]   blk;
  logic [LOCAL_W-1:0] lcl [N_CORES];

  assign blk = host_addr[ADDR_W-1:8];

  function automatic logic in_rgn(input logic [BLK_W-1:0] b, input int base, input int cnt);
    int bi;
    bi = int'(b);
    return (bi >= base) && (bi < base + cnt);
  endfunction

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    localparam int BASE = csel_pkg::blk_base(CNTS, g);
    localparam int CNT  = int'(CORE_BLOCKS[g*8 +: 8]);
    logic [BLK_W-1:0] rel;
    assign hit[g]  = host_cs && in_rgn(blk, BASE, CNT);
    assign rel     = blk - BLK_W'(BASE);
    assign lcl[g]  = LOCAL_W'({rel, host_addr[7:0]});
  end

  always_comb begin
    lcl_addr = '0;
    for (int i = 0; i < N_CORES; i++)
      if (hit[i]) lcl_addr = lcl_addr | lcl[i];
  end

  assign unmapped   = host_cs && (hit == '0);
  assign err_masked = core_err_in & CORE_ERR;
endmodule

// File: rtl/csel_align.sv
module csel_align #(
  parameter int N_CORES = 4,
  parameter logic [N_CORES-1:0] CORE_BRAM = 4'b1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CORES-1:0]     hit,
  input  logic                   unmapped,
  input  logic [32*N_CORES-1:0]  rd_in,
  input  logic [N_CORES-1:0]     er_in,
  output logic [N_CORES-1:0]     sel,
  output logic                   unm,
  output logic [32*N_CORES-1:0]  rd_out,
  output logic [N_CORES-1:0]     er_out
);
  localparam bit ANY_BRAM = |CORE_BRAM;

  if (ANY_BRAM) begin : g_lat
    logic [N_CORES-1:0] sel_q;
    logic               unm_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q <= '0;
        unm_q <= 1'b0;
      end else begin
        sel_q <= hit;
        unm_q <= unmapped;
      end
    end
    assign sel = sel_q;
    assign unm = unm_q;

    for (genvar g = 0; g < N_CORES; g++) begin : g_core
      if (CORE_BRAM[g]) begin : g_mem
        assign rd_out[g*32 +: 32] = rd_in[g*32 +: 32];
        assign er_out[g]          = er_in[g];
      end else begin : g_reg
        logic [31:0] rd_q;
        logic        er_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            rd_q <= '0;
            er_q <= 1'b0;
          end else begin
            rd_q <= rd_in[g*32 +: 32];
            er_q <= er_in[g];
          end
        end
        assign rd_out[g*32 +: 32] = rd_q;
        assign er_out[g]          = er_q;
      end
    end
  end else begin : g_comb
    assign sel    = hit;
    assign unm    = unmapped;
    assign rd_out = rd_in;
    assign er_out = er_in;
  end
endmodule

// File: rtl/csel_rmux.sv
module csel_rmux #(
  parameter int N_CORES = 4
) (
  input  logic [N_CORES-1:0]     sel,
  input  logic                   unm,
  input  logic [32*N_CORES-1:0]  rd,
  input  logic [N_CORES-1:0]     er,
  output logic [31:0]            host_rdata,
  output logic                   host_err
);
  always_comb begin
    host_rdata = '0;
    host_err   = unm;
    for (int i = 0; i < N_CORES; i++) begin
      if (sel[i]) begin
        host_rdata = host_rdata | rd[i*32 +: 32];
        host_err   = host_err | er[i];
      end
    end
  end
endmodule

// File: rtl/csel_top.sv
module csel_top #(
  parameter int ADDR_W = 24,
  parameter int N_CORES = 4,
  parameter logic [N_CORES*8-1:0] CORE_BLOCKS = {8'd4, 8'd16, 8'd1, 8'd1},
  parameter logic [N_CORES-1:0] CORE_BRAM = 4'b1000,
  parameter logic [N_CORES-1:0] CORE_ERR = 4'b0101,
  localparam int LOCAL_W = csel_pkg::local_width(csel_pkg::cnt_vec_t'(CORE_BLOCKS), N_CORES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_cs,
  input  logic                  host_we,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [31:0]           host_wdata,
  output logic [31:0]           host_rdata,
  output logic                  host_err,
  output logic [N_CORES-1:0]    core_cs,
  output logic [N_CORES-1:0]    core_we,
  output logic [LOCAL_W-1:0]    core_addr,
  output logic [31:0]           core_wdata,
  input  logic [32*N_CORES-1:0] core_rdata,
  input  logic [N_CORES-1:0]    core_err_in
);
  // named internal events
  logic [N_CORES-1:0]    req_hit;
  logic                  req_unmapped;
  logic [N_CORES-1:0]    req_err;
  logic [N_CORES-1:0]    rsp_sel;
  logic                  rsp_unmapped;
  logic [32*N_CORES-1:0] rsp_rdata;
  logic [N_CORES-1:0]    rsp_err;

  csel_decode #(
    .ADDR_W(ADDR_W), .N_CORES(N_CORES), .CORE_BLOCKS(CORE_BLOCKS),
    .CORE_ERR(CORE_ERR), .LOCAL_W(LOCAL_W)
  ) u_decode (
    .host_cs(host_cs), .host_addr(host_addr), .core_err_in(core_err_in),
    .hit(req_hit), .unmapped(req_unmapped), .lcl_addr(core_addr),
    .err_masked(req_err)
  );

  csel_align #(.N_CORES(N_CORES), .CORE_BRAM(CORE_BRAM)) u_align (
    .clk(clk), .rst_n(rst_n), .hit(req_hit), .unmapped(req_unmapped),
    .rd_in(core_rdata), .er_in(req_err),
    .sel(rsp_sel), .unm(rsp_unmapped), .rd_out(rsp_rdata), .er_out(rsp_err)
  );

  csel_rmux #(.N_CORES(N_CORES)) u_rmux (
    .sel(rsp_sel), .unm(rsp_unmapped), .rd(rsp_rdata), .er(rsp_err),
    .host_rdata(host_rdata), .host_err(host_err)
  );

  assign core_cs    = req_hit;
  assign core_we    = req_hit & {N_CORES{host_we}};
  assign core_wdata = host_wdata;
endmodule

// File: rtl/csel_top_chk.sv
module csel_top_chk #(
  parameter int N_CORES = 4,
  parameter bit ANY_BRAM = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_cs,
  input logic               host_we,
  input logic [31:0]        host_rdata,
  input logic               host_err,
  input logic [N_CORES-1:0] core_cs,
  input logic [N_CORES-1:0] core_we
);
  a_r4_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_cs));

  a_r1_cs_needs_host: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_cs) |-> host_cs);

  a_r3_we_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_we) |-> (host_we && ((core_we & ~core_cs) == '0)));

  a_r3_we_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_we) |-> (core_we == core_cs));

  if (ANY_BRAM) begin : g_lat
    a_r8_unmapped_err: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cs && core_cs == '0) |=> (host_err && host_rdata == '0));
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !host_cs |=> (!host_err && host_rdata == '0));
  end else begin : g_comb
    a_r10_unmapped_err: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cs && core_cs == '0) |-> (host_err && host_rdata == '0));
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !host_cs |-> (!host_err && host_rdata == '0));
  end
endmodule

bind csel_top csel_top_chk #(.N_CORES(N_CORES), .ANY_BRAM(|CORE_BRAM)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
  .host_rdata(host_rdata), .host_err(host_err),
  .core_cs(core_cs), .core_we(core_we)
);

// File: tb/test_csel_top.sv
`timescale 1ns/1ps
module test_csel_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs = 1'b0;
  logic        host_we = 1'b0;
  logic [23:0] host_addr = '0;
  logic [31:0] host_wdata = 32'h1234_5678;
  logic [31:0] host_rdata;
  logic        host_err;
  logic [3:0]  core_cs, core_we;
  logic [11:0] core_addr;
  logic [31:0] core_wdata;
  logic [127:0] core_rdata;
  logic [3:0]  core_err_in;
  logic [31:0] bram_q;

  // instance built without block memory
  logic [31:0] n_rdata;
  logic        n_err;
  logic [3:0]  n_cs, n_we;
  logic [11:0] n_addr;
  logic [31:0] n_wdata;
  logic [127:0] n_core_rdata;
  logic [3:0]  n_core_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input int c, input logic [11:0] l);
    return {4'hC, 4'(c), 12'h000, l};
  endfunction

  // core models: cores 0..2 register-based, core 3 block memory
  for (genvar g = 0; g < 3; g++) begin : g_fm
    assign core_rdata[g*32 +: 32] = core_cs[g] ? pat(g, core_addr) : 32'hDEAD_0000;
  end
  always @(posedge clk) bram_q <= core_cs[3] ? pat(3, core_addr) : 32'hDEAD_0003;
  assign core_rdata[127:96] = bram_q;
  assign core_err_in = {1'b1, core_cs[2] && core_addr[7:0] == 8'hEE,
                        1'b1, core_cs[0] && core_addr[7:0] == 8'hEE};

  for (genvar g = 0; g < 4; g++) begin : g_nm
    assign n_core_rdata[g*32 +: 32] = n_cs[g] ? pat(g, n_addr) : 32'hDEAD_0000;
  end
  assign n_core_err = {1'b1, n_cs[2] && n_addr[7:0] == 8'hEE,
                       1'b1, n_cs[0] && n_addr[7:0] == 8'hEE};

  csel_top i_csel_top (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_err(host_err), .core_cs(core_cs), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .core_err_in(core_err_in)
  );

  csel_top #(.CORE_BRAM(4'b0000)) i_nobram (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(n_rdata),
    .host_err(n_err), .core_cs(n_cs), .core_we(n_we),
    .core_addr(n_addr), .core_wdata(n_wdata), .core_rdata(n_core_rdata),
    .core_err_in(n_core_err)
  );

  // expected model, from the region layout in the requirements
  function automatic int core_of(input logic [23:0] a);
    int b;
    b = int'(a[23:8]);
    if (b == 0) return 0;
    if (b == 1) return 1;
    if (b >= 2 && b < 18) return 2;
    if (b >= 18 && b < 22) return 3;
    return -1;
  endfunction

  function automatic logic [11:0] local_of(input logic [23:0] a);
    int b, base;
    b = int'(a[23:8]);
    case (core_of(a))
      0: base = 0;
      1: base = 1;
      2: base = 2;
      3: base = 18;
      default: base = b;
    endcase
    return {4'(b - base), a[7:0]};
  endfunction

  function automatic logic [31:0] exp_data(input logic [23:0] a);
    return (core_of(a) < 0) ? 32'h0 : pat(core_of(a), local_of(a));
  endfunction

  function automatic logic exp_err(input logic [23:0] a);
    int c;
    c = core_of(a);
    if (c < 0) return 1'b1;
    return (c == 0 || c == 2) && a[7:0] == 8'hEE;
  endfunction

  function automatic logic [3:0] exp_cs(input logic [23:0] a);
    return (core_of(a) < 0) ? 4'b0 : 4'(1 << core_of(a));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(host_rdata == 32'h0, "R9 reset rdata", host_rdata, 32'h0);
    chk(host_err == 1'b0, "R9 reset err", 32'(host_err), 32'h0);
  endtask

  task automatic t_decode;
    logic [23:0] al [7] = '{24'h000012, 24'h0001FF, 24'h000234, 24'h001105,
                           24'h001200, 24'h0015AB, 24'h001600};
    foreach (al[i]) begin
      @(negedge clk);
      host_cs = 1'b1; host_we = 1'b0; host_addr = al[i];
      #1;
      chk(core_cs == exp_cs(al[i]), "R1 decode core_cs", 32'(core_cs), 32'(exp_cs(al[i])));
      chk($countones(core_cs) <= 1, "R4 single select", 32'(core_cs), 32'(exp_cs(al[i])));
      if (core_of(al[i]) >= 0)
        chk(core_addr == local_of(al[i]), "R2 local address", 32'(core_addr), 32'(local_of(al[i])));
    end
    @(negedge clk);
    host_cs = 1'b0;
  endtask

  task automatic t_write;
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b1; host_addr = 24'h000345;
    #1;
    chk(core_we == 4'b0100, "R3 write to core2", 32'(core_we), 32'h4);
    chk(core_wdata == host_wdata, "R3 write data", core_wdata, host_wdata);
    @(negedge clk);
    host_we = 1'b0;
    #1;
    chk(core_we == 4'b0000, "R3 read has no we", 32'(core_we), 32'h0);
    @(negedge clk);
    host_cs = 1'b0; host_we = 1'b1;
    #1;
    chk(core_we == 4'b0000, "R3 we without cs", 32'(core_we), 32'h0);
    chk(core_cs == 4'b0000, "R4 no cs when idle", 32'(core_cs), 32'h0);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic read_one(input logic [23:0] a, input string req);
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_cs = 1'b0;
    chk(host_rdata == exp_data(a), req, host_rdata, exp_data(a));
    chk(host_err == exp_err(a), {req, " err"}, 32'(host_err), 32'(exp_err(a)));
  endtask

  task automatic t_read_each;
    read_one(24'h000010, "R5 core0 read");
    read_one(24'h000120, "R5 core1 read");
    read_one(24'h000F30, "R5 core2 read");
    read_one(24'h001340, "R5 core3 read");
  endtask

  task automatic t_b2b;
    logic [23:0] seq [5] = '{24'h001201, 24'h000002, 24'h0015FE, 24'h000103, 24'h000504};
    @(negedge clk);
    host_cs = 1'b1; host_addr = seq[0];
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (i < 5) host_addr = seq[i];
      else host_cs = 1'b0;
      chk(host_rdata == exp_data(seq[i-1]), "R6 back-to-back order", host_rdata, exp_data(seq[i-1]));
    end
  endtask

  task automatic t_err;
    read_one(24'h0000EE, "R7 core0 error");
    read_one(24'h0001EE, "R7 core1 no error output");
    read_one(24'h0007EE, "R7 core2 error");
    read_one(24'h0014EE, "R7 core3 no error output");
  endtask

  task automatic t_unmapped;
    @(negedge clk);
    host_cs = 1'b1; host_addr = 24'h001600;
    #1;
    chk(core_cs == 4'b0, "R8 unmapped no cs", 32'(core_cs), 32'h0);
    @(negedge clk);
    host_addr = 24'hFFFFFF;
    chk(host_rdata == 32'h0, "R8 unmapped rdata", host_rdata, 32'h0);
    chk(host_err == 1'b1, "R8 unmapped err", 32'(host_err), 32'h1);
    @(negedge clk);
    host_cs = 1'b0;
    chk(host_err == 1'b1, "R8 top address err", 32'(host_err), 32'h1);
    @(negedge clk);
    chk(host_rdata == 32'h0 && host_err == 1'b0, "R9 idle after request",
        {host_rdata[30:0], host_err}, 32'h0);
  endtask

  task automatic t_nobram;
    logic [23:0] al [4] = '{24'h001302, 24'h000011, 24'h0002EE, 24'h001700};
    foreach (al[i]) begin
      @(negedge clk);
      host_cs = 1'b1; host_addr = al[i];
      #1;
      chk(n_rdata == exp_data(al[i]), "R10 same-cycle data", n_rdata, exp_data(al[i]));
      chk(n_err == exp_err(al[i]), "R10 same-cycle err", 32'(n_err), 32'(exp_err(al[i])));
    end
    @(negedge clk);
    host_cs = 1'b0;
    #1;
    chk(n_rdata == 32'h0 && n_err == 1'b0, "R10 idle zero", n_rdata, 32'h0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_write();
    t_read_each();
    t_b2b();
    t_err();
    t_unmapped();
    t_nobram();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule